// File: doc/BRIEF.md
# Virtual Bridge Type 1 Configuration Header

This block holds the type 1 configuration header of a virtual PCI-to-PCI bridge placed behind a root port or a switch port. Enumeration software reaches it through a dword-indexed configuration read/write port with byte enables. Identity, class and capability-pointer fields are fixed. The command register, the three bus numbers and the compressed memory and I/O base/limit fields can be written by software.

The routing logic next to the bridge never parses the header. It takes the bus numbers as plain outputs, together with two decoded forwarding windows. The memory window comes from the 12-bit base and limit fields, holding address bits 31:20, with the low 20 bits filled. The I/O window comes from two 4-bit fields, holding address bits 15:12, with the low 12 bits filled and a fixed upper half. Each window has a valid flag. A one-cycle refresh pulse tells the range logic to pick up new window values.

Top module: `p2p_type1_hdr`

## Requirements
- R1: Dword 0 reads {device ID parameter, 16'h8086}. Dword 3 reads 32'h0001_0000, which puts the header type value 1 in bits 23:16. Dword 13 reads 32'h0000_00D8, the capability pointer. Dword 2 reads {24'h060400, revision parameter}. Writes to all of these dwords are ignored.
- R2: After reset, dword 1 reads 32'h0010_0007: the status half has only bit 4 set, and the command half has the I/O, memory and bus-master bits 2:0 set. Command bits 10:0 are writable. Command bits 15:11 and the whole status half are read-only.
- R3: Command writes change only the value read back. They do not change the window outputs, the valid flags or the refresh pulse.
- R4: Dwords 4 and 5, the bridge's own base address registers, always read 0, even after all-ones writes.
- R5: In dword 6, byte 0 holds the primary bus number, byte 1 the secondary and byte 2 the subordinate. All three reset to 0. Each byte is written only when its byte enable is set. The bus outputs show a new value from the first clock edge after the write. Byte 3 reads 0.
- R6: In dword 8, bits 15:4 are memory base address bits 31:20 and bits 31:20 are memory limit address bits 31:20. Bits 3:0 and 19:16 read 0. The memory window output is base = {field, 20'h00000} and limit = {field, 20'hFFFFF}.
- R7: In dword 7, bits 7:4 are I/O base address bits 15:12 and bits 15:12 are I/O limit address bits 15:12. Bits 3:0 and 11:8 read 1, and bits 31:16 read 0. Dword 12 reads 32'h2F00_2F00. The I/O window output is base = {16'h2F00, field, 12'h000} and limit = {16'h2F00, field, 12'hFFF}.
- R8: A window's valid flag is 0 after reset. It is 1 only when both its base and its limit field have been written since reset and the base is not above the limit, equal fields included.
- R9: A write to dword 8 with any byte enable set, or to dword 7 with byte enable 0 or 1 set, raises the refresh output for exactly one cycle. The pulse comes on the second clock edge after the write, the same edge at which the window outputs and valid flags update. A write to dword 7 with only byte enables 3:2 set raises no pulse.
- R10: Read data and its valid strobe appear on the first clock edge after the read request, and the strobe lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write request |
| cfg_rd_en | input | 1 | Configuration read request |
| cfg_idx | input | 4 | Dword index within the 64-byte header |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Write byte enables |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid, one cycle |
| pri_bus | output | 8 | Primary bus number |
| sec_bus | output | 8 | Secondary bus number |
| sub_bus | output | 8 | Subordinate bus number |
| mem_base | output | 32 | Expanded memory window base |
| mem_limit | output | 32 | Expanded memory window limit |
| mem_valid | output | 1 | Memory window valid |
| io_base | output | 32 | Expanded I/O window base |
| io_limit | output | 32 | Expanded I/O window limit |
| io_valid | output | 1 | I/O window valid |
| win_refresh | output | 1 | One-cycle window refresh pulse |

## Verification
A corrupted base or limit field shows up two ways: in the readback one edge after the read request, and on the expanded window outputs two edges after the write. A wrong written-since-reset flag shows up only on the valid outputs. The bench therefore writes one field at a time and checks validity between the writes, and it also drives a base above the limit and a base equal to the limit. A misaligned or missing refresh strobe is caught by sampling the pulse in the cycle the windows change and again one cycle later. Writes that must not touch the windows, such as command writes and writes to the secondary status bytes, are followed by checks of the pulse and the window outputs.

// File: rtl/p2p_hdr_pkg.sv
package p2p_hdr_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned MEM_FILL  = 20;
  localparam int unsigned IO_FILL   = 12;
  localparam int unsigned MEM_FW    = ADDR_W - MEM_FILL;
  localparam int unsigned IO_FW     = 16 - IO_FILL;

  // dword indices decoded by enumeration software
  localparam int unsigned DW_IDENT  = 0;
  localparam int unsigned DW_CMDSTS = 1;
  localparam int unsigned DW_CLASS  = 2;
  localparam int unsigned DW_HTYPE  = 3;
  localparam int unsigned DW_BUS    = 6;
  localparam int unsigned DW_IOWIN  = 7;
  localparam int unsigned DW_MEMWIN = 8;
  localparam int unsigned DW_IOUP   = 12;
  localparam int unsigned DW_CAP    = 13;

  typedef struct packed {
    logic [7:0] sub;
    logic [7:0] sec;
    logic [7:0] pri;
  } bus_nums_t;
endpackage

// File: rtl/p2p_hdr_regs.sv
module p2p_hdr_regs
  import p2p_hdr_pkg::*;
#(
  parameter int unsigned IDX_W     = 4,
  parameter logic [15:0] CMD_RESET = 16'h0007,
  parameter logic [15:0] CMD_WMASK = 16'h07FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [15:0]       cmd_q,
  output bus_nums_t         bus_q,
  output logic [MEM_FW-1:0] mbase_f,
  output logic [MEM_FW-1:0] mlimit_f,
  output logic [IO_FW-1:0]  iobase_f,
  output logic [IO_FW-1:0]  iolimit_f,
  output logic              mbase_set,
  output logic              mlimit_set,
  output logic              iobase_set,
  output logic              iolimit_set,
  output logic              mem_strobe,
  output logic              io_strobe
);
  logic hit_cmd, hit_bus, hit_io, hit_mem;

  always_comb begin
    hit_cmd = wr_en && (wr_idx == IDX_W'(DW_CMDSTS));
    hit_bus = wr_en && (wr_idx == IDX_W'(DW_BUS));
    hit_io  = wr_en && (wr_idx == IDX_W'(DW_IOWIN));
    hit_mem = wr_en && (wr_idx == IDX_W'(DW_MEMWIN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= CMD_RESET;
      bus_q       <= '0;
      mbase_f     <= '0;
      mlimit_f    <= '0;
      iobase_f    <= '0;
      iolimit_f   <= '0;
      mbase_set   <= 1'b0;
      mlimit_set  <= 1'b0;
      iobase_set  <= 1'b0;
      iolimit_set <= 1'b0;
      mem_strobe  <= 1'b0;
      io_strobe   <= 1'b0;
    end else begin
      mem_strobe <= hit_mem && (|be);
      io_strobe  <= hit_io && (|be[1:0]);
      if (hit_cmd) begin
        if (be[0]) cmd_q[7:0]  <= (wdata[7:0]  & CMD_WMASK[7:0])  | (cmd_q[7:0]  & ~CMD_WMASK[7:0]);
        if (be[1]) cmd_q[15:8] <= (wdata[15:8] & CMD_WMASK[15:8]) | (cmd_q[15:8] & ~CMD_WMASK[15:8]);
      end
      if (hit_bus) begin
        if (be[0]) bus_q.pri <= wdata[7:0];
        if (be[1]) bus_q.sec <= wdata[15:8];
        if (be[2]) bus_q.sub <= wdata[23:16];
      end
      if (hit_mem) begin
        if (be[0]) mbase_f[3:0]   <= wdata[7:4];
        if (be[1]) mbase_f[11:4]  <= wdata[15:8];
        if (be[2]) mlimit_f[3:0]  <= wdata[23:20];
        if (be[3]) mlimit_f[11:4] <= wdata[31:24];
        if (|be[1:0]) mbase_set  <= 1'b1;
        if (|be[3:2]) mlimit_set <= 1'b1;
      end
      if (hit_io) begin
        if (be[0]) begin
          iobase_f   <= wdata[7:4];
          iobase_set <= 1'b1;
        end
        if (be[1]) begin
          iolimit_f   <= wdata[15:12];
          iolimit_set <= 1'b1;
        end
      end
    end
  end

  // R5
  bus_sec_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_bus && be[1]) |=> (bus_q.sec == $past(wdata[15:8])));

  // R6
  mem_limit_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_mem && be[3]) |=> (mlimit_f[11:4] == $past(wdata[31:24])));
endmodule

// File: rtl/p2p_win_expand.sv
module p2p_win_expand #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FIELD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FIELD_W-1:0] base_f,
  input  logic [FIELD_W-1:0] limit_f,
  input  logic              base_set,
  input  logic              limit_set,
  input  logic              strobe,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] limit_q,
  output logic              valid_q,
  output logic              refresh_q
);
  localparam int unsigned FILL_W = ADDR_W - FIELD_W;

  always_ff @(posedge clk) begin
    base_q  <= {base_f, {FILL_W{1'b0}}};
    limit_q <= {limit_f, {FILL_W{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      refresh_q <= 1'b0;
    end else begin
      valid_q   <= base_set && limit_set && (base_f <= limit_f);
      refresh_q <= strobe;
    end
  end

  // R8
  win_order_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (base_q <= limit_q));

  // R9
  win_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(base_q) || !$stable(limit_q)) |-> refresh_q);
endmodule

// File: rtl/p2p_hdr_rdmux.sv
module p2p_hdr_rdmux
  import p2p_hdr_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter logic [15:0] DEV_ID   = 16'h9C90,
  parameter logic [15:0] VEND_ID  = 16'h8086,
  parameter logic [7:0]  REV_ID   = 8'h00,
  parameter logic [15:0] IO_UPPER = 16'h2F00,
  parameter logic [7:0]  CAP_PTR  = 8'hD8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [15:0]       cmd_q,
  input  bus_nums_t         bus_q,
  input  logic [MEM_FW-1:0] mbase_f,
  input  logic [MEM_FW-1:0] mlimit_f,
  input  logic [IO_FW-1:0]  iobase_f,
  input  logic [IO_FW-1:0]  iolimit_f,
  output logic [31:0]       rdata_q,
  output logic              rvalid_q
);
  localparam logic [15:0] STATUS_VAL = 16'h0010;
  localparam logic [23:0] CLASS_BRG  = 24'h060400;
  localparam logic [7:0]  HDR_TYPE1  = 8'h01;

  logic [31:0] sel;

  always_comb begin
    sel = '0;
    case (rd_idx)
      IDX_W'(DW_IDENT):  sel = {DEV_ID, VEND_ID};
      IDX_W'(DW_CMDSTS): sel = {STATUS_VAL, cmd_q};
      IDX_W'(DW_CLASS):  sel = {CLASS_BRG, REV_ID};
      IDX_W'(DW_HTYPE):  sel = {8'h00, HDR_TYPE1, 16'h0000};
      IDX_W'(DW_BUS):    sel = {8'h00, bus_q};
      IDX_W'(DW_IOWIN):  sel = {16'h0000, iolimit_f, 4'h1, iobase_f, 4'h1};
      IDX_W'(DW_MEMWIN): sel = {mlimit_f, 4'h0, mbase_f, 4'h0};
      IDX_W'(DW_IOUP):   sel = {IO_UPPER, IO_UPPER};
      IDX_W'(DW_CAP):    sel = {24'h000000, CAP_PTR};
      default:           sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= sel;
    end
  end

  // R1
  ident_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid_q && ($past(rd_idx) == IDX_W'(DW_IDENT))) |-> (rdata_q == {DEV_ID, VEND_ID}));
endmodule

// File: rtl/p2p_type1_hdr.sv
module p2p_type1_hdr
  import p2p_hdr_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 64,
  parameter logic [15:0] DEV_ID    = 16'h9C90,
  parameter logic [7:0]  REV_ID    = 8'h00,
  parameter logic [15:0] IO_UPPER  = 16'h2F00,
  parameter logic [7:0]  CAP_PTR   = 8'hD8,
  parameter logic [15:0] CMD_RESET = 16'h0007,
  parameter logic [15:0] CMD_WMASK = 16'h07FF,
  localparam int unsigned IDX_W    = $clog2(HDR_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic [3:0]        cfg_be,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  output logic [7:0]        pri_bus,
  output logic [7:0]        sec_bus,
  output logic [7:0]        sub_bus,
  output logic [ADDR_W-1:0] mem_base,
  output logic [ADDR_W-1:0] mem_limit,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] io_base,
  output logic [ADDR_W-1:0] io_limit,
  output logic              io_valid,
  output logic              win_refresh
);
  localparam int unsigned IO_EXT_W = ADDR_W - IO_FILL;

  logic [15:0]       cmd_q;
  bus_nums_t         bus_q;
  logic [MEM_FW-1:0] mbase_f, mlimit_f;
  logic [IO_FW-1:0]  iobase_f, iolimit_f;
  logic              mbase_set, mlimit_set, iobase_set, iolimit_set;
  logic              mem_strobe, io_strobe;
  logic              mem_refresh, io_refresh;

  p2p_hdr_regs #(
    .IDX_W(IDX_W), .CMD_RESET(CMD_RESET), .CMD_WMASK(CMD_WMASK)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .wr_idx(cfg_idx),
    .wdata(cfg_wdata), .be(cfg_be), .cmd_q(cmd_q), .bus_q(bus_q),
    .mbase_f(mbase_f), .mlimit_f(mlimit_f),
    .iobase_f(iobase_f), .iolimit_f(iolimit_f),
    .mbase_set(mbase_set), .mlimit_set(mlimit_set),
    .iobase_set(iobase_set), .iolimit_set(iolimit_set),
    .mem_strobe(mem_strobe), .io_strobe(io_strobe)
  );

  p2p_hdr_rdmux #(
    .IDX_W(IDX_W), .DEV_ID(DEV_ID), .VEND_ID(16'h8086), .REV_ID(REV_ID),
    .IO_UPPER(IO_UPPER), .CAP_PTR(CAP_PTR)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(cfg_rd_en), .rd_idx(cfg_idx),
    .cmd_q(cmd_q), .bus_q(bus_q), .mbase_f(mbase_f), .mlimit_f(mlimit_f),
    .iobase_f(iobase_f), .iolimit_f(iolimit_f),
    .rdata_q(cfg_rdata), .rvalid_q(cfg_rvalid)
  );

  p2p_win_expand #(.ADDR_W(ADDR_W), .FIELD_W(MEM_FW)) u_mem_win (
    .clk(clk), .rst(rst), .base_f(mbase_f), .limit_f(mlimit_f),
    .base_set(mbase_set), .limit_set(mlimit_set), .strobe(mem_strobe),
    .base_q(mem_base), .limit_q(mem_limit), .valid_q(mem_valid),
    .refresh_q(mem_refresh)
  );

  p2p_win_expand #(.ADDR_W(ADDR_W), .FIELD_W(IO_EXT_W)) u_io_win (
    .clk(clk), .rst(rst),
    .base_f({IO_UPPER, iobase_f}), .limit_f({IO_UPPER, iolimit_f}),
    .base_set(iobase_set), .limit_set(iolimit_set), .strobe(io_strobe),
    .base_q(io_base), .limit_q(io_limit), .valid_q(io_valid),
    .refresh_q(io_refresh)
  );

  assign pri_bus     = bus_q.pri;
  assign sec_bus     = bus_q.sec;
  assign sub_bus     = bus_q.sub;
  assign win_refresh = mem_refresh | io_refresh;
endmodule

// File: tb/p2p_type1_hdr_bench.sv
module p2p_type1_hdr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [7:0]  pri_bus, sec_bus, sub_bus;
  logic [31:0] mem_base, mem_limit, io_base, io_limit;
  logic        mem_valid, io_valid, win_refresh;
  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  p2p_type1_hdr u_p2p_type1_hdr (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .mem_base(mem_base), .mem_limit(mem_limit), .mem_valid(mem_valid),
    .io_base(io_base), .io_limit(io_limit), .io_valid(io_valid),
    .win_refresh(win_refresh)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic wr(input logic [3:0] idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_idx = idx; cfg_wdata = d; cfg_be = be;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_be = '0;
  endtask

  task automatic rdw(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_idx = idx;
    @(posedge clk); #1;
    d = cfg_rvalid ? cfg_rdata : 32'hDEAD_BEEF;
    @(negedge clk);
    cfg_rd_en = 1'b0;
  endtask

  // after wr(): next edge updates windows and raises the pulse
  task automatic win_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rdw(4'd1, rd); chk("R2 cmd/status reset", rd, 32'h0010_0007);
    rdw(4'd6, rd); chk("R5 bus reset", rd, 32'h0);
    chk("R5 bus outputs reset", {8'h0, sub_bus, sec_bus, pri_bus}, 32'h0);
    rdw(4'd7, rd); chk("R7 io reset read", rd, 32'h0000_0101);
    rdw(4'd8, rd); chk("R6 mem reset read", rd, 32'h0);
    chk("R8 mem valid reset", {31'h0, mem_valid}, 32'h0);
    chk("R8 io valid reset", {31'h0, io_valid}, 32'h0);
    chk("R6 mem limit reset", mem_limit, 32'h000F_FFFF);
    chk("R7 io base reset", io_base, 32'h2F00_0000);
    chk("R9 no pulse at rest", {31'h0, win_refresh}, 32'h0);
  endtask

  task automatic t_identity();
    wr(4'd0, 32'hFFFF_FFFF, 4'hF);
    wr(4'd2, 32'hFFFF_FFFF, 4'hF);
    wr(4'd3, 32'hFFFF_FFFF, 4'hF);
    wr(4'd13, 32'hFFFF_FFFF, 4'hF);
    wr(4'd12, 32'h0, 4'hF);
    rdw(4'd0, rd);  chk("R1 ident", rd, 32'h9C90_8086);
    rdw(4'd2, rd);  chk("R1 class", rd, 32'h0604_0000);
    rdw(4'd3, rd);  chk("R1 header type", rd, 32'h0001_0000);
    rdw(4'd13, rd); chk("R1 cap ptr", rd, 32'h0000_00D8);
    rdw(4'd12, rd); chk("R7 io upper", rd, 32'h2F00_2F00);
  endtask

  task automatic t_bars();
    wr(4'd4, 32'hFFFF_FFFF, 4'hF);
    wr(4'd5, 32'hFFFF_FFFF, 4'hF);
    rdw(4'd4, rd); chk("R4 bar0", rd, 32'h0);
    rdw(4'd5, rd); chk("R4 bar1", rd, 32'h0);
  endtask

  task automatic t_command();
    wr(4'd1, 32'hFFFF_FFFF, 4'hF);
    win_edge();
    chk("R3 no pulse on cmd write", {31'h0, win_refresh}, 32'h0);
    chk("R3 mem base unchanged", mem_base, 32'h0);
    chk("R3 mem valid unchanged", {31'h0, mem_valid}, 32'h0);
    rdw(4'd1, rd); chk("R2 cmd writable bits", rd, 32'h0010_07FF);
    wr(4'd1, 32'h0000_0000, 4'b0010);
    rdw(4'd1, rd); chk("R2 cmd byte-enable", rd, 32'h0010_00FF);
  endtask

  task automatic t_bus();
    wr(4'd6, 32'hAA05_0301, 4'b0111);
    chk("R5 bus outputs", {8'h0, sub_bus, sec_bus, pri_bus}, 32'h0005_0301);
    rdw(4'd6, rd); chk("R5 bus read", rd, 32'h0005_0301);
    wr(4'd6, 32'h0000_0900, 4'b0010);
    chk("R5 only secondary", {8'h0, sub_bus, sec_bus, pri_bus}, 32'h0005_0901);
  endtask

  task automatic t_mem();
    wr(4'd8, 32'h0000_3000, 4'b0011);
    win_edge();
    chk("R9 pulse mem base", {31'h0, win_refresh}, 32'h1);
    chk("R6 mem base expand", mem_base, 32'h3000_0000);
    chk("R8 limit unwritten", {31'h0, mem_valid}, 32'h0);
    @(posedge clk); #1;
    chk("R9 pulse one cycle", {31'h0, win_refresh}, 32'h0);
    wr(4'd8, 32'h4000_0000, 4'b1100);
    win_edge();
    chk("R6 mem limit expand", mem_limit, 32'h400F_FFFF);
    chk("R8 mem valid", {31'h0, mem_valid}, 32'h1);
    rdw(4'd8, rd); chk("R6 mem read", rd, 32'h4000_3000);
    wr(4'd8, 32'h0000_500F, 4'b0011);
    win_edge();
    chk("R8 base above limit", {31'h0, mem_valid}, 32'h0);
    rdw(4'd8, rd); chk("R6 low nibble zero", rd, 32'h4000_5000);
    wr(4'd8, 32'h0000_4000, 4'b0011);
    win_edge();
    chk("R8 base equals limit", {31'h0, mem_valid}, 32'h1);
  endtask

  task automatic t_io();
    wr(4'd7, 32'h0000_00A5, 4'b0001);
    win_edge();
    chk("R9 pulse io base", {31'h0, win_refresh}, 32'h1);
    chk("R7 io base expand", io_base, 32'h2F00_A000);
    chk("R8 io limit unwritten", {31'h0, io_valid}, 32'h0);
    wr(4'd7, 32'h0000_C300, 4'b0010);
    win_edge();
    chk("R7 io limit expand", io_limit, 32'h2F00_CFFF);
    chk("R8 io valid", {31'h0, io_valid}, 32'h1);
    rdw(4'd7, rd); chk("R7 io read", rd, 32'h0000_C1A1);
    wr(4'd7, 32'hFFFF_0000, 4'b1100);
    win_edge();
    chk("R9 no pulse status bytes", {31'h0, win_refresh}, 32'h0);
    rdw(4'd7, rd); chk("R7 status bytes ignored", rd, 32'h0000_C1A1);
  endtask

  task automatic t_read_latency();
    rdw(4'd0, rd);
    @(posedge clk); #1;
    chk("R10 rvalid single cycle", {31'h0, cfg_rvalid}, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_identity();
    t_bars();
    t_command();
    t_bus();
    t_mem();
    t_io();
    t_read_latency();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule